// File: doc/BRIEF.md
# Sixteen-bit ALU with flags

This block is the arithmetic and logic unit of a small graphics coprocessor. Given a source operand, a second operand (either a register value or a zero-extended 4-bit immediate), the incoming carry and an operation code, it produces a result word, a write-enable for the destination register, and the next values of the sign, zero, carry and overflow flags. The datapath is combinational; only the four flags are held in a register inside the block, loaded on a clock edge when the flag-enable input is high.

Flag behaviour departs from a textbook ALU in several places. The merge operation builds every flag from byte-pair bit masks. The halve operation rounds minus one to zero. The byte-extraction operations take sign from bit 7. Operations that have no arithmetic meaning for carry or overflow pass the stored flags through unchanged. The surrounding core owns the register file, instruction fetch and the multiplier, and wires the stored carry back to the carry input. All ports are plain control and data pins with no handshake, because each result is valid in the same cycle its operands are presented.

Top module: `gfx_alu`

## Requirements
- R1: ADD (op 0) gives the low 16 bits of a+b and ADC (op 1) of a+b+cin; carry is set when the unsigned sum is 0x10000 or more, sign is result bit 15, zero is set for a zero result.
- R2: For ADD and ADC, overflow is bit 15 of (NOT(a XOR b)) AND (b XOR result).
- R3: SUB (op 2) gives a-b and SBC (op 3) gives a-b-(1-cin); carry is set when no borrow occurs (the true difference is not negative), and overflow is bit 15 of (a XOR b) AND (a XOR result).
- R4: CMP (op 4) updates all four flags exactly as SUB does, while wr_en stays low.
- R5: AND (op 5), BIC a AND NOT b (op 6), OR (op 7), XOR (op 8), NOT a (op 9), SWAP (op 14) and SEXT (op 15) update sign (bit 15) and zero only; carry and overflow keep their stored values.
- R6: LSR (op 10) and ASR (op 11) shift right by one and load carry with old bit 0; ROL (op 12) shifts cin into bit 0 and loads carry with old bit 15; ROR (op 13) shifts cin into bit 15 and loads carry with old bit 0; overflow is held.
- R7: HALVE (op 19) is an arithmetic shift right by one, except that 0xFFFF gives 0; carry receives old bit 0.
- R8: LOB (op 16) returns the low byte and HIB (op 17) the high byte, both in bits 7:0 with the upper byte zero; sign comes from result bit 7.
- R9: SWAP exchanges the two bytes of a; SEXT copies bit 7 of a into the whole upper byte.
- R10: MERGE (op 18) returns {mrg_hi, mrg_lo}; overflow, sign, carry and zero are each set when any result bit is set under the masks 0xC0C0, 0x8080, 0xE0E0 and 0xF0F0 respectively.
- R11: The stored flags load the next-flag values on a rising edge only while flag_en is high, and a synchronous reset clears all four.
- R12: Op codes 20 to 31 drive wr_en low and next flags equal to the stored flags.
- R13: With use_imm high the second operand is imm zero-extended to 16 bits; otherwise it is reg_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous reset, clears stored flags |
| op | input | 5 | Operation code |
| src_a | input | 16 | Source operand |
| reg_b | input | 16 | Register second operand |
| imm | input | 4 | Immediate second operand |
| use_imm | input | 1 | Select the immediate as second operand |
| cin | input | 1 | Incoming carry |
| mrg_hi | input | 8 | High byte of the first merge register |
| mrg_lo | input | 8 | High byte of the second merge register |
| flag_en | input | 1 | Load the flag register at the next edge |
| res | output | 16 | Result word |
| wr_en | output | 1 | Destination write-enable |
| nxt_s | output | 1 | Next sign flag |
| nxt_z | output | 1 | Next zero flag |
| nxt_c | output | 1 | Next carry flag |
| nxt_v | output | 1 | Next overflow flag |
| flg_s | output | 1 | Stored sign flag |
| flg_z | output | 1 | Stored zero flag |
| flg_c | output | 1 | Stored carry flag |
| flg_v | output | 1 | Stored overflow flag |

## Verification
The bench builds the block with its defaults, a 16-bit data width and a 4-bit immediate, so byte boundaries sit at bit 7 and bit 15 and the largest immediate is 15. At this width the wrap of 0xFFFF plus one, the 0x8000 overflow corners, the 0xFFFF halve exception and the per-byte merge masks can all be reached with hand-picked operands. Carry and overflow are first forced high so that the held-flag behaviour of the logic and byte operations becomes visible, and a cycle with flag_en low shows that the stored flags stay unchanged.

// File: rtl/gfx_alu_pkg.sv
package gfx_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADC   = 5'd1,
    OP_SUB   = 5'd2,
    OP_SBC   = 5'd3,
    OP_CMP   = 5'd4,
    OP_AND   = 5'd5,
    OP_BIC   = 5'd6,
    OP_OR    = 5'd7,
    OP_XOR   = 5'd8,
    OP_NOT   = 5'd9,
    OP_LSR   = 5'd10,
    OP_ASR   = 5'd11,
    OP_ROL   = 5'd12,
    OP_ROR   = 5'd13,
    OP_SWAP  = 5'd14,
    OP_SEXT  = 5'd15,
    OP_LOB   = 5'd16,
    OP_HIB   = 5'd17,
    OP_MERGE = 5'd18,
    OP_HALVE = 5'd19
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

endpackage

// File: rtl/gfx_alu_addsub.sv
module gfx_alu_addsub #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  input  logic          use_cin,
  output logic [DW-1:0] sum,
  output logic          c_out,
  output logic          v_out
);

  localparam int MSB = DW - 1;

  logic [DW:0]   wide;
  logic [DW-1:0] b_in;
  logic          c_in;

  always_comb begin
    b_in  = sub ? ~b : b;
    c_in  = use_cin ? cin : sub;
    wide  = {1'b0, a} + {1'b0, b_in} + {{DW{1'b0}}, c_in};
    sum   = wide[DW-1:0];
    c_out = wide[DW];
    if (sub)
      v_out = (a[MSB] ^ b[MSB]) & (a[MSB] ^ sum[MSB]);
    else
      v_out = ~(a[MSB] ^ b[MSB]) & (b[MSB] ^ sum[MSB]);
  end

endmodule

// File: rtl/gfx_alu_bitops.sv
module gfx_alu_bitops
  import gfx_alu_pkg::*;
#(
  parameter int DW = 16,
  localparam int HB = DW / 2
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic [HB-1:0] mh,
  input  logic [HB-1:0] ml,
  output logic [DW-1:0] res,
  output logic          c_out
);

  logic [DW-1:0] asr1;

  always_comb begin
    asr1  = {a[DW-1], a[DW-1:1]};
    res   = '0;
    c_out = a[0];
    case (op)
      OP_AND:   res = a & b;
      OP_BIC:   res = a & ~b;
      OP_OR:    res = a | b;
      OP_XOR:   res = a ^ b;
      OP_NOT:   res = ~a;
      OP_LSR:   res = {1'b0, a[DW-1:1]};
      OP_ASR:   res = asr1;
      OP_HALVE: res = (&a) ? '0 : asr1;
      OP_ROL: begin
        res   = {a[DW-2:0], cin};
        c_out = a[DW-1];
      end
      OP_ROR:   res = {cin, a[DW-1:1]};
      OP_SWAP:  res = {a[HB-1:0], a[DW-1:HB]};
      OP_SEXT:  res = {{HB{a[HB-1]}}, a[HB-1:0]};
      OP_LOB:   res = {{HB{1'b0}}, a[HB-1:0]};
      OP_HIB:   res = {{HB{1'b0}}, a[DW-1:HB]};
      OP_MERGE: res = {mh, ml};
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/gfx_alu_flagreg.sv
module gfx_alu_flagreg
  import gfx_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  alu_flags_t d,
  output alu_flags_t q
);

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (en)
      q <= d;
  end

  p_rst_clear_r11: assert property (@(posedge clk) rst |=> (q == '0));
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));
  p_load_r11: assert property (@(posedge clk) disable iff (rst)
    en |=> (q == $past(d)));

endmodule

// File: rtl/gfx_alu.sv
module gfx_alu
  import gfx_alu_pkg::*;
#(
  parameter int DW   = 16,
  parameter int IMMW = 4,
  localparam int HB  = DW / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [4:0]      op,
  input  logic [DW-1:0]   src_a,
  input  logic [DW-1:0]   reg_b,
  input  logic [IMMW-1:0] imm,
  input  logic            use_imm,
  input  logic            cin,
  input  logic [HB-1:0]   mrg_hi,
  input  logic [HB-1:0]   mrg_lo,
  input  logic            flag_en,
  output logic [DW-1:0]   res,
  output logic            wr_en,
  output logic            nxt_s,
  output logic            nxt_z,
  output logic            nxt_c,
  output logic            nxt_v,
  output logic            flg_s,
  output logic            flg_z,
  output logic            flg_c,
  output logic            flg_v
);

  alu_op_e       opc;
  logic [DW-1:0] b_eff;
  logic [DW-1:0] as_sum;
  logic          as_c;
  logic          as_v;
  logic          as_sub;
  logic          as_usec;
  logic [DW-1:0] bo_res;
  logic          bo_c;
  alu_flags_t    cf;
  alu_flags_t    nf;

  assign opc     = alu_op_e'(op);
  assign b_eff   = use_imm ? {{(DW-IMMW){1'b0}}, imm} : reg_b;
  assign as_sub  = (opc == OP_SUB) || (opc == OP_SBC) || (opc == OP_CMP);
  assign as_usec = (opc == OP_ADC) || (opc == OP_SBC);

  gfx_alu_addsub #(.DW(DW)) u_addsub (
    .a       (src_a),
    .b       (b_eff),
    .cin     (cin),
    .sub     (as_sub),
    .use_cin (as_usec),
    .sum     (as_sum),
    .c_out   (as_c),
    .v_out   (as_v)
  );

  gfx_alu_bitops #(.DW(DW)) u_bitops (
    .op    (opc),
    .a     (src_a),
    .b     (b_eff),
    .cin   (cin),
    .mh    (mrg_hi),
    .ml    (mrg_lo),
    .res   (bo_res),
    .c_out (bo_c)
  );

  // Result select and flag rules per operation class.
  always_comb begin
    res   = bo_res;
    wr_en = 1'b1;
    nf    = cf;
    case (opc)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
        res   = as_sum;
        nf.s  = as_sum[DW-1];
        nf.z  = (as_sum == '0);
        nf.c  = as_c;
        nf.v  = as_v;
        wr_en = (opc != OP_CMP);
      end
      OP_AND, OP_BIC, OP_OR, OP_XOR, OP_NOT, OP_SWAP, OP_SEXT: begin
        nf.s = bo_res[DW-1];
        nf.z = (bo_res == '0);
      end
      OP_LSR, OP_ASR, OP_ROL, OP_ROR, OP_HALVE: begin
        nf.s = bo_res[DW-1];
        nf.z = (bo_res == '0);
        nf.c = bo_c;
      end
      OP_LOB, OP_HIB: begin
        nf.s = bo_res[HB-1];
        nf.z = (bo_res == '0);
      end
      OP_MERGE: begin
        nf.v = |{bo_res[DW-1 -: 2], bo_res[HB-1 -: 2]};
        nf.s = bo_res[DW-1] | bo_res[HB-1];
        nf.c = |{bo_res[DW-1 -: 3], bo_res[HB-1 -: 3]};
        nf.z = |{bo_res[DW-1 -: 4], bo_res[HB-1 -: 4]};
      end
      default: begin
        res   = '0;
        wr_en = 1'b0;
      end
    endcase
  end

  gfx_alu_flagreg u_flags (
    .clk (clk),
    .rst (rst),
    .en  (flag_en),
    .d   (nf),
    .q   (cf)
  );

  assign {nxt_s, nxt_z, nxt_c, nxt_v} = nf;
  assign {flg_s, flg_z, flg_c, flg_v} = cf;

  p_add_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (opc == OP_ADD) |-> (nxt_c == (res < src_a)));
  p_sub_noborrow_r3: assert property (@(posedge clk) disable iff (rst)
    (opc == OP_SUB) |-> (nxt_c == (src_a >= b_eff)));
  p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
    (opc == OP_CMP) |-> !wr_en);
  p_logic_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (opc inside {OP_AND, OP_BIC, OP_OR, OP_XOR, OP_NOT, OP_SWAP, OP_SEXT})
      |-> (nxt_c == flg_c && nxt_v == flg_v));
  p_halve_neg1_r7: assert property (@(posedge clk) disable iff (rst)
    (opc == OP_HALVE && (&src_a)) |-> (res == '0 && nxt_z && nxt_c));
  p_byte_upper_r8: assert property (@(posedge clk) disable iff (rst)
    (opc == OP_LOB || opc == OP_HIB) |-> (res[DW-1:HB] == '0));
  p_undef_r12: assert property (@(posedge clk) disable iff (rst)
    (op > 5'd19) |-> (!wr_en && nf == cf));

endmodule

// File: tb/gfx_alu_bench.sv
module gfx_alu_bench;

  typedef struct packed {
    logic [15:0] res;
    logic        we;
    logic [3:0]  nf;
    logic [3:0]  cf;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op = '0;
  logic [15:0] src_a = '0;
  logic [15:0] reg_b = '0;
  logic [3:0]  imm = '0;
  logic        use_imm = 1'b0;
  logic        cin = 1'b0;
  logic [7:0]  mrg_hi = '0;
  logic [7:0]  mrg_lo = '0;
  logic        flag_en = 1'b0;
  logic [15:0] res;
  logic        wr_en, nxt_s, nxt_z, nxt_c, nxt_v, flg_s, flg_z, flg_c, flg_v;

  int   errors = 0;
  int   checks = 0;
  logic [3:0] mflags = '0;
  exp_t q_exp[$];
  string q_tag[$];

  always #5 clk = ~clk;

  gfx_alu u_gfx_alu (
    .clk(clk), .rst(rst), .op(op), .src_a(src_a), .reg_b(reg_b), .imm(imm),
    .use_imm(use_imm), .cin(cin), .mrg_hi(mrg_hi), .mrg_lo(mrg_lo),
    .flag_en(flag_en), .res(res), .wr_en(wr_en),
    .nxt_s(nxt_s), .nxt_z(nxt_z), .nxt_c(nxt_c), .nxt_v(nxt_v),
    .flg_s(flg_s), .flg_z(flg_z), .flg_c(flg_c), .flg_v(flg_v)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // Expected behaviour written from the requirements; flags as {s,z,c,v}.
  function automatic exp_t model(input logic [4:0] o, input logic [15:0] a,
                                 input logic [15:0] b, input logic ci,
                                 input logic [7:0] mh, input logic [7:0] ml,
                                 input logic [3:0] cur);
    exp_t e;
    logic s, z, c, v, we;
    logic [15:0] r;
    logic [16:0] w;
    int d;
    {s, z, c, v} = cur;
    we = 1'b1;
    r  = '0;
    case (o)
      5'd0, 5'd1: begin
        w = {1'b0, a} + {1'b0, b} + 17'((o == 5'd1) && ci);
        r = w[15:0]; c = w[16];
        v = (a[15] == b[15]) && (r[15] != a[15]);
        s = r[15]; z = (r == 0);
      end
      5'd2, 5'd3, 5'd4: begin
        d = int'(a) - int'(b) - (((o == 5'd3) && !ci) ? 1 : 0);
        r = d[15:0]; c = (d >= 0);
        v = (a[15] != b[15]) && (r[15] != a[15]);
        s = r[15]; z = (r == 0); we = (o != 5'd4);
      end
      5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd14, 5'd15: begin
        case (o)
          5'd5:  r = a & b;
          5'd6:  r = a & ~b;
          5'd7:  r = a | b;
          5'd8:  r = a ^ b;
          5'd9:  r = ~a;
          5'd14: r = {a[7:0], a[15:8]};
          default: r = a[7] ? (16'hFF00 | a) : (16'h00FF & a);
        endcase
        s = r[15]; z = (r == 0);
      end
      5'd10: begin r = a >> 1; c = a[0]; s = r[15]; z = (r == 0); end
      5'd11: begin r = 16'($signed(a) >>> 1); c = a[0]; s = r[15]; z = (r == 0); end
      5'd19: begin
        r = (a == 16'hFFFF) ? 16'h0000 : 16'($signed(a) >>> 1);
        c = a[0]; s = r[15]; z = (r == 0);
      end
      5'd12: begin r = {a[14:0], ci}; c = a[15]; s = r[15]; z = (r == 0); end
      5'd13: begin r = {ci, a[15:1]}; c = a[0]; s = r[15]; z = (r == 0); end
      5'd16: begin r = {8'h00, a[7:0]}; s = r[7]; z = (r == 0); end
      5'd17: begin r = {8'h00, a[15:8]}; s = r[7]; z = (r == 0); end
      5'd18: begin
        r = {mh, ml};
        v = (r & 16'hC0C0) != 0; s = (r & 16'h8080) != 0;
        c = (r & 16'hE0E0) != 0; z = (r & 16'hF0F0) != 0;
      end
      default: we = 1'b0;
    endcase
    e.res = r; e.we = we; e.nf = {s, z, c, v}; e.cf = cur;
    return e;
  endfunction

  // Driver: presents one operation per cycle and queues what it expects.
  task automatic apply(input string tag, input logic [4:0] o, input logic [15:0] a,
                       input logic [15:0] b, input logic ci, input logic en,
                       input logic ui = 1'b0, input logic [3:0] im = 4'h0,
                       input logic [7:0] mh = 8'h00, input logic [7:0] ml = 8'h00);
    exp_t e;
    logic [15:0] beff;
    @(negedge clk);
    op = o; src_a = a; reg_b = b; cin = ci; flag_en = en;
    use_imm = ui; imm = im; mrg_hi = mh; mrg_lo = ml;
    beff = ui ? {12'h000, im} : b;
    e = model(o, a, beff, ci, mh, ml, mflags);
    q_exp.push_back(e);
    q_tag.push_back(tag);
    if (en) mflags = e.nf;
  endtask

  // Monitor: pops one expectation per cycle and compares the ports.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q_exp.size() > 0) begin
        exp_t e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (e.we) chk(res === e.res, t, "result", 32'(res), 32'(e.res));
        chk(wr_en === e.we, t, "wr_en", 32'(wr_en), 32'(e.we));
        chk({nxt_s, nxt_z, nxt_c, nxt_v} === e.nf, t, "next flags",
            32'({nxt_s, nxt_z, nxt_c, nxt_v}), 32'(e.nf));
        chk({flg_s, flg_z, flg_c, flg_v} === e.cf, t, "stored flags (R11)",
            32'({flg_s, flg_z, flg_c, flg_v}), 32'(e.cf));
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; flag_en = 1'b0;
    @(negedge clk);
    rst = 1'b0; mflags = '0;
    #2;
    chk({flg_s, flg_z, flg_c, flg_v} === 4'b0000, "R11", "flags after reset",
        32'({flg_s, flg_z, flg_c, flg_v}), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    chk({flg_s, flg_z, flg_c, flg_v} === 4'b0000, "R11", "reset state",
        32'({flg_s, flg_z, flg_c, flg_v}), 32'h0);
    // R1 add / add with carry
    apply("R1", 5'd0, 16'hFFFF, 16'h0001, 1'b0, 1'b1);
    apply("R1", 5'd0, 16'h1234, 16'h0001, 1'b0, 1'b1);
    apply("R1", 5'd1, 16'h00FF, 16'h0001, 1'b1, 1'b1);
    // R2 add overflow
    apply("R2", 5'd0, 16'h7FFF, 16'h0001, 1'b0, 1'b1);
    apply("R2", 5'd1, 16'h7FFF, 16'h0000, 1'b1, 1'b1);
    apply("R2", 5'd0, 16'h8000, 16'h8000, 1'b0, 1'b1);
    // R5 logic ops keep c=1 v=1 from the previous add
    apply("R5", 5'd5, 16'hF0F0, 16'h0FF0, 1'b0, 1'b1);
    apply("R5", 5'd6, 16'hFFFF, 16'h00FF, 1'b0, 1'b1);
    apply("R5", 5'd7, 16'h0000, 16'h0000, 1'b0, 1'b1);
    apply("R5", 5'd8, 16'hAAAA, 16'h5555, 1'b0, 1'b1);
    apply("R5", 5'd9, 16'hFFFF, 16'h0000, 1'b0, 1'b1);
    // R9 swap and sign extend (flags still carry c, v)
    apply("R9", 5'd14, 16'h12AB, 16'h0000, 1'b0, 1'b1);
    apply("R9", 5'd15, 16'h0080, 16'h0000, 1'b0, 1'b1);
    apply("R9", 5'd15, 16'hFF7F, 16'h0000, 1'b0, 1'b1);
    // R8 byte extraction
    apply("R8", 5'd16, 16'h12F0, 16'h0000, 1'b0, 1'b1);
    apply("R8", 5'd17, 16'h8012, 16'h0000, 1'b0, 1'b1);
    apply("R8", 5'd17, 16'h00FF, 16'h0000, 1'b0, 1'b1);
    // R3 subtract / subtract with borrow
    apply("R3", 5'd2, 16'h0005, 16'h0005, 1'b0, 1'b1);
    apply("R3", 5'd2, 16'h0000, 16'h0001, 1'b0, 1'b1);
    apply("R3", 5'd3, 16'h0005, 16'h0002, 1'b0, 1'b1);
    apply("R3", 5'd3, 16'h0005, 16'h0002, 1'b1, 1'b1);
    apply("R3", 5'd2, 16'h8000, 16'h0001, 1'b0, 1'b1);
    // R4 compare
    apply("R4", 5'd4, 16'h0003, 16'h0007, 1'b0, 1'b1);
    apply("R4", 5'd4, 16'h0009, 16'h0009, 1'b0, 1'b1);
    // R6 shifts and rotates
    apply("R6", 5'd10, 16'h0003, 16'h0000, 1'b0, 1'b1);
    apply("R6", 5'd11, 16'h8001, 16'h0000, 1'b0, 1'b1);
    apply("R6", 5'd12, 16'h8000, 16'h0000, 1'b1, 1'b1);
    apply("R6", 5'd13, 16'h0001, 16'h0000, 1'b0, 1'b1);
    apply("R6", 5'd13, 16'h0002, 16'h0000, 1'b1, 1'b1);
    // R7 halve
    apply("R7", 5'd19, 16'hFFFF, 16'h0000, 1'b0, 1'b1);
    apply("R7", 5'd19, 16'hFFFE, 16'h0000, 1'b0, 1'b1);
    apply("R7", 5'd19, 16'h0005, 16'h0000, 1'b0, 1'b1);
    // R10 merge masks
    apply("R10", 5'd18, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 4'h0, 8'h40, 8'h10);
    apply("R10", 5'd18, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 4'h0, 8'h00, 8'h80);
    apply("R10", 5'd18, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 4'h0, 8'h0F, 8'h0F);
    // R13 immediate operand
    apply("R13", 5'd0, 16'h0001, 16'h1000, 1'b0, 1'b1, 1'b1, 4'hF);
    apply("R13", 5'd2, 16'h0003, 16'h0000, 1'b0, 1'b1, 1'b1, 4'h4);
    // R11 flag enable low: stored flags must not change
    apply("R11", 5'd0, 16'hFFFF, 16'h0001, 1'b0, 1'b0);
    apply("R11", 5'd9, 16'h0000, 16'h0000, 1'b0, 1'b0);
    // R12 undefined codes
    apply("R12", 5'd25, 16'h1234, 16'h4321, 1'b1, 1'b1);
    apply("R12", 5'd31, 16'h0000, 16'hFFFF, 1'b0, 1'b1);
    // R11 reset clears flags set to non-zero
    apply("R11", 5'd0, 16'h8000, 16'h8000, 1'b0, 1'b1);
    do_reset();
    apply("R11", 5'd7, 16'h0001, 16'h0000, 1'b0, 1'b1);
    @(negedge clk);
    flag_en = 1'b0;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule